// File: doc/BRIEF.md
# Mode-Selectable Output Post-Divider

This block sits between a VCO clock and one output bank. It turns the fast input clock into the bank clock under the control of a 2-bit mode field and a 10-bit divide value. The mode can hold the bank silent, pass the input clock straight through, halve it, or divide it by the programmed value plus two. A silenced bank keeps all of its logic alive. Selecting a running mode again brings the clock back without any reset.

The programmable and fixed divisions come from a registered counter, so the output edges follow rising input edges. The divide-by-1 path is the input clock itself, gated by an enable that is retimed on the falling edge, so the gate never cuts a high phase short. Mode and divide-value changes are held until the current output period ends. This way no shortened or stretched pulse ever reaches the bank.

Top module: `clk_post_div`

## Requirements
- R1: While reset is high, and after it is released with mode 00 applied, the output is low.
- R2: Mode code 00 (mode_sel = 2'b00) holds the output at logic 0 with no toggling.
- R3: Mode code 01 passes the input clock through: the output is high during the input's high phase and low during its low phase.
- R4: Mode code 10 divides by 2: output period of 2 input cycles, high for 1.
- R5: Mode code 11 divides by q_val + 2, where q_val is the unsigned 10-bit value on q_val[9:0].
- R6: In mode 11 with an even ratio, the output is high for exactly ratio/2 input cycles of each period.
- R7: In mode 11 with an odd ratio, the output is high for (ratio+1)/2 input cycles of each period.
- R8: A change of mode or of q_val made during an output period does not alter that period. The new setting starts at the next period boundary.
- R9: After a stay in mode 00, selecting a running mode restores a correct clock with no reset applied.
- R10: The divide extremes hold: q_val = 0 gives a ratio of 2, and q_val = 1023 gives a ratio of 1025, high for 513 cycles.
- R11: In modes 00, 01 and 10, the value of q_val has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 off, 01 pass-through, 10 divide by 2, 11 divide by q_val+2 |
| q_val | input | 10 | Programmable divide value for mode 11 |
| clk_out | output | 1 | Divided bank clock |

## Verification
The bench changes the divide value partway through a long period. A design that loads the new setting at once would cut that period short and emit a runt pulse. It also drives the odd ratio 3 and the extreme ratio 1025. An off-by-one in the high-time rule or an overflow of the counter width would show there as a wrong high count or a wrong period. In pass-through mode both clock phases are sampled, so a registered copy or a stuck gate cannot pass. The bench also toggles q_val in the fixed modes and leaves and re-enters the off mode, which catches decoding that leaks q_val and state that only a reset would clear.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    localparam int Q_W = 10;
    localparam int R_W = Q_W + 1;

    typedef enum logic [1:0] {
        PD_OFF  = 2'b00,
        PD_BYP  = 2'b01,
        PD_HALF = 2'b10,
        PD_PROG = 2'b11
    } pd_mode_e;

    typedef struct packed {
        pd_mode_e       mode;
        logic [R_W-1:0] ratio;
        logic [R_W-1:0] high;
    } pd_cfg_t;

    function automatic logic [R_W-1:0] ratio_of(pd_mode_e m, logic [Q_W-1:0] q);
        logic [R_W-1:0] r;
        case (m)
            PD_OFF:  r = '0;
            PD_BYP:  r = R_W'(1);
            PD_HALF: r = R_W'(2);
            default: r = R_W'(q) + R_W'(2);
        endcase
        return r;
    endfunction

    function automatic logic [R_W-1:0] high_of(logic [R_W-1:0] r);
        logic [R_W:0] t;
        t = {1'b0, r} + (R_W+1)'(1);
        return t[R_W:1];
    endfunction

    function automatic logic is_div(pd_mode_e m);
        return (m == PD_HALF) || (m == PD_PROG);
    endfunction

    function automatic pd_cfg_t decode(logic [1:0] sel, logic [Q_W-1:0] q);
        pd_cfg_t c;
        c.mode  = pd_mode_e'(sel);
        c.ratio = ratio_of(c.mode, q);
        c.high  = high_of(c.ratio);
        return c;
    endfunction

endpackage

// File: rtl/pdiv_cfg_hold.sv
module pdiv_cfg_hold
    import pdiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     mode_sel,
    input  logic [Q_W-1:0] q_val,
    input  logic           wrap,
    output pd_cfg_t        cur_o,
    output pd_cfg_t        nxt_o
);
    pd_cfg_t pend;
    pd_cfg_t cur_r;
    pd_cfg_t reset_cfg;

    always_comb begin
        pend      = decode(mode_sel, q_val);
        reset_cfg = decode(2'b00, '0);
        nxt_o     = wrap ? pend : cur_r;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_r <= reset_cfg;
        else     cur_r <= nxt_o;
    end

    assign cur_o = cur_r;

    // R8: settings only move at a period boundary
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cur_r));

endmodule

// File: rtl/pdiv_count.sv
module pdiv_count
    import pdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pd_cfg_t cur,
    input  pd_cfg_t nxt,
    output logic    wrap,
    output logic    div_o
);
    logic [R_W-1:0] cnt;
    logic [R_W-1:0] n_cnt;
    logic           n_out;
    logic           out_r;

    always_comb begin
        wrap  = !is_div(cur.mode) || (cnt == cur.ratio - R_W'(1));
        n_cnt = wrap ? '0 : cnt + R_W'(1);
        n_out = is_div(nxt.mode) && (n_cnt < nxt.high);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            out_r <= 1'b0;
        end else begin
            cnt   <= n_cnt;
            out_r <= n_out;
        end
    end

    assign div_o = out_r;

    // R5: counter never leaves the programmed period
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        is_div(cur.mode) |-> (cnt < cur.ratio));

    // R4: divide by 2 toggles every cycle once settled
    p_half_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (cur.mode == PD_HALF && $past(cur.mode) == PD_HALF) |-> (out_r != $past(out_r)));

    // R7: high phase ends exactly after the rounded-up half
    p_high_len_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(out_r) && is_div(cur.mode)) |-> (cnt == cur.high));

endmodule

// File: rtl/pdiv_gate.sv
module pdiv_gate (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    output logic en_o,
    output logic gclk_o
);
    logic en_n;

    always_ff @(negedge clk) begin
        if (rst) en_n <= 1'b0;
        else     en_n <= en_req;
    end

    assign en_o   = en_n;
    assign gclk_o = clk & en_n;

endmodule

// File: rtl/clk_post_div.sv
module clk_post_div
    import pdiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     mode_sel,
    input  logic [Q_W-1:0] q_val,
    output logic           clk_out
);
    pd_cfg_t cur;
    pd_cfg_t nxt;
    logic    wrap;
    logic    div_q;
    logic    gate_en;
    logic    gclk;

    pdiv_cfg_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .q_val    (q_val),
        .wrap     (wrap),
        .cur_o    (cur),
        .nxt_o    (nxt)
    );

    pdiv_count u_count (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur),
        .nxt   (nxt),
        .wrap  (wrap),
        .div_o (div_q)
    );

    pdiv_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .en_req (cur.mode == PD_BYP),
        .en_o   (gate_en),
        .gclk_o (gclk)
    );

    assign clk_out = gclk | div_q;

    // R3: pass-through gate and divider never drive together
    p_path_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(gate_en && div_q));

    // R2: settled off mode keeps both paths quiet
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cur.mode == PD_OFF && $past(cur.mode) == PD_OFF) |-> (!div_q && !gate_en));

endmodule

// File: tb/clk_post_div_bench.sv
`timescale 1ns/1ps
module clk_post_div_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic [9:0] q_val = '0;
    logic       clk_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    clk_post_div u_clk_post_div (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .q_val    (q_val),
        .clk_out  (clk_out)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // move to the middle of the high phase of the next input cycle
    task automatic tick();
        @(posedge clk);
        #2.5;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic sync_rise();
        int g = 0;
        while (clk_out !== 1'b0 && g < 3000) begin tick(); g++; end
        while (clk_out !== 1'b1 && g < 3000) begin tick(); g++; end
    endtask

    // called on the first high sample of a period; stops on the next one
    task automatic count_from_rise(output int hi, output int per);
        logic seen_low = 1'b0;
        int   g = 0;
        hi = 1; per = 1;
        forever begin
            tick();
            g++;
            if ((clk_out === 1'b1 && seen_low) || g > 3000) break;
            if (clk_out !== 1'b1) seen_low = 1'b1;
            if (!seen_low) hi++;
            per++;
        end
    endtask

    task automatic meas(output int hi, output int per);
        sync_rise();
        count_from_rise(hi, per);
    endtask

    task automatic t_reset();
        ticks(3);
        check(clk_out === 1'b0, "R1 high-phase during reset", clk_out, 0);
        #5;
        check(clk_out === 1'b0, "R1 low-phase during reset", clk_out, 0);
        @(posedge clk); #2.5;
        rst = 1'b0;
        ticks(3);
        check(clk_out === 1'b0, "R1 after release", clk_out, 0);
    endtask

    task automatic t_off();
        int bad = 0;
        mode_sel = 2'b00;
        ticks(30);
        for (int i = 0; i < 20; i++) begin
            if (clk_out !== 1'b0) bad++;
            #5;
            if (clk_out !== 1'b0) bad++;
            q_val = 10'(i * 37);
            tick();
        end
        check(bad == 0, "R2 off mode quiet", bad, 0);
        check(bad == 0, "R11 q ignored when off", bad, 0);
    endtask

    task automatic t_bypass();
        int bad = 0;
        mode_sel = 2'b01;
        ticks(4);
        for (int i = 0; i < 10; i++) begin
            if (clk_out !== 1'b1) bad++;
            #5;
            if (clk_out !== 1'b0) bad++;
            q_val = 10'(i * 91 + 5);
            tick();
        end
        check(bad == 0, "R3 pass-through follows clock", bad, 0);
        check(bad == 0, "R11 q ignored in pass-through", bad, 0);
    endtask

    task automatic t_half();
        int hi, per;
        mode_sel = 2'b10;
        meas(hi, per);
        check(per == 2, "R4 half period", per, 2);
        check(hi == 1, "R4 half high", hi, 1);
        q_val = 10'd1000;
        ticks(5);
        meas(hi, per);
        check(per == 2 && hi == 1, "R11 q ignored in half mode", per * 10 + hi, 21);
    endtask

    task automatic t_prog(input int q, input string req);
        int hi, per, er, eh;
        er = q + 2;
        eh = (er + 1) / 2;
        q_val = 10'(q);
        mode_sel = 2'b11;
        meas(hi, per);
        meas(hi, per);
        check(per == er, {req, " R5 period"}, per, er);
        check(hi == eh, {req, " high time"}, hi, eh);
    endtask

    task automatic t_midperiod();
        int hi, per;
        q_val = 10'd8;
        mode_sel = 2'b11;
        meas(hi, per);
        meas(hi, per);
        q_val = 10'd1;
        count_from_rise(hi, per);
        check(per == 10, "R8 old period kept", per, 10);
        check(hi == 5, "R8 old high kept", hi, 5);
        count_from_rise(hi, per);
        check(per == 3, "R8 new period applied", per, 3);
        check(hi == 2, "R8 new high applied", hi, 2);
        mode_sel = 2'b10;
        ticks(1);
        count_from_rise(hi, per);
        check(per == 2, "R8 mode change at boundary", per, 2);
    endtask

    task automatic t_resume();
        int hi, per;
        mode_sel = 2'b00;
        ticks(20);
        check(clk_out === 1'b0, "R9 off before resume", clk_out, 0);
        q_val = 10'd4;
        mode_sel = 2'b11;
        meas(hi, per);
        check(per == 6 && hi == 3, "R9 resume without reset", per * 10 + hi, 63);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_off();
        t_bypass();
        t_half();
        t_prog(8, "R6 even ratio 10");
        t_prog(1, "R7 odd ratio 3");
        t_prog(0, "R10 q=0 ratio 2");
        t_prog(1023, "R10 q=1023 ratio 1025");
        t_midperiod();
        t_resume();
        t_off();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule